// File: doc/BRIEF.md
# Compressed Half-Density Integer Dot-Product Accumulator

This block computes a running integer dot product where the weight operand has been pruned so that no more than two of every four consecutive weights are nonzero, and the nonzero weights arrive in packed form. Each cycle one weight group is presented: two signed 8-bit weight values, each paired with a 2-bit lane index, together with the full group of four signed 8-bit activations. The index of each slot steers a four-way activation select. Only the two selected activations are multiplied by their weights. Both products are added into a 32-bit accumulator in the same cycle. Two multipliers therefore cover a four-wide dense group, and the zero weights are never multiplied.

A dot product starts with a group flagged as first, which loads the accumulator from a supplied starting value before that group's products are added (D = A*B + C). It ends with a group flagged as last. The total is presented one cycle later with a single-cycle valid pulse. A small controller tracks the dot in progress with three states. `S_IDLE` means no dot is open. `S_RUN` means a dot is open and accumulating. `S_DONE` means a result is being presented. The transitions are as follows:
- START: any state to `S_RUN`, on an accepted first group that is not last.
- STEP: `S_RUN` stays in `S_RUN`, on an accepted non-last group.
- FINISH: any state to `S_DONE`, on an accepted last group.
- RETIRE: `S_DONE` to `S_IDLE`, when no group is accepted.
- WAIT: `S_IDLE` stays in `S_IDLE`, when no group is accepted.

A group whose indices are not strictly increasing is malformed. It is flagged and adds nothing to the total.

Top module: `sparse_dot24`

## Requirements
- R1: After reset, `res_valid` and `idx_err` are 0 and `res_data` is 0.
- R2: Slot k (k = 0, 1) holds its weight in `wt_val[8k+7:8k]` and its index in `wt_idx[2k+1:2k]`. The index selects activation lane j, which sits in `act[8j+7:8j]`. A group's contribution is the sum over both slots of weight times selected activation, with all values signed two's complement.
- R3: A group with `grp_valid` and `grp_first` both high is accepted in every state. It replaces the accumulator with `init_c` plus that group's contribution, and any dot already open is abandoned.
- R4: An accepted group without `grp_first` adds its contribution to the running total. All sums wrap modulo 2^32.
- R5: When an accepted group has `grp_last` high, `res_valid` is high for exactly the cycle after the clock edge that took the group, and `res_data` then holds the total including that group. `res_valid` is high at no other time.
- R6: When an accepted group has `wt_idx[1:0]` >= `wt_idx[3:2]`, `idx_err` is high in the following cycle. That group adds nothing to the total. When it is also first, the total becomes `init_c`.
- R7: A cycle with `grp_valid` low changes nothing: there is no result, no error, and the running total is unchanged.
- R8: A valid group without `grp_first` that arrives while no dot is open (`S_IDLE` or `S_DONE`) is ignored. It changes no total, raises no result and raises no error.
- R9: A new first group may arrive in the cycle right after a last group. It is accepted, so results can be produced every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A weight group is presented this cycle |
| grp_first | input | 1 | Group opens a new dot and loads `init_c` |
| grp_last | input | 1 | Group closes the dot |
| wt_val | input | 16 | Two packed signed 8-bit kept weights |
| wt_idx | input | 4 | Two packed 2-bit lane indices |
| act | input | 32 | Four packed signed 8-bit activations |
| init_c | input | 32 | Starting accumulator value for a first group |
| res_data | output | 32 | Final dot total, qualified by `res_valid` |
| res_valid | output | 1 | One-cycle pulse when a total is presented |
| idx_err | output | 1 | Previous accepted group had malformed indices |

## Verification
A corrupted controller state appears at the ports within one group. If the block wrongly believes a dot is open, a stray non-first group becomes a visible result or error pulse. If it wrongly believes no dot is open, the next total is missing a group's contribution. A wrong lane select or a wrong index check shifts the very next `res_data`, or raises `idx_err` out of step. Because every dot ends in a compared total, an accumulator error can stay hidden only until the next `res_valid`.

// File: rtl/sd24_pkg.sv
package sd24_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } sd24_state_t;

endpackage

// File: rtl/sd24_lane_sel.sv
module sd24_lane_sel #(
    parameter int DW  = 8,
    parameter int GRP = 4,
    parameter int IW  = $clog2(GRP)
) (
    input  logic [GRP*DW-1:0] lanes,
    input  logic [IW-1:0]     pick,
    output logic [DW-1:0]     chosen
);

    always_comb begin
        chosen = '0;
        for (int j = 0; j < GRP; j++) begin
            if (pick == IW'(j)) begin
                chosen = lanes[j*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/sd24_mul.sv
module sd24_mul #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic [DW-1:0] op_w,
    input  logic [DW-1:0] op_a,
    output logic [AW-1:0] prod
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] full;

    assign full = $signed(op_w) * $signed(op_a);
    assign prod = {{(AW-PW){full[PW-1]}}, full};

endmodule

// File: rtl/sd24_ctrl.sv
module sd24_ctrl
    import sd24_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_valid,
    input  logic          grp_first,
    input  logic          grp_last,
    input  logic          grp_bad,
    input  logic [AW-1:0] grp_sum,
    input  logic [AW-1:0] init_c,
    output logic [AW-1:0] res_data,
    output logic          res_valid,
    output logic          idx_err
);

    sd24_state_t state_q, state_d;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] base;
    logic [AW-1:0] acc_next;
    logic          accept;

    assign accept   = grp_valid && (grp_first || state_q == S_RUN);
    assign base     = grp_first ? init_c : acc_q;
    assign acc_next = base + (grp_bad ? '0 : grp_sum);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = grp_last ? S_DONE : S_RUN;
            end
            S_RUN: begin
                if (accept) state_d = grp_last ? S_DONE : S_RUN;
            end
            S_DONE: begin
                if (accept) state_d = grp_last ? S_DONE : S_RUN;
                else        state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            res_data <= '0;
            idx_err  <= 1'b0;
        end else begin
            idx_err <= accept && grp_bad;
            if (accept) begin
                acc_q <= acc_next;
                if (grp_last) res_data <= acc_next;
            end
        end
    end

    assign res_valid = (state_q == S_DONE);

    // R5
    last_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_last && (grp_first || state_q == S_RUN)) |=> res_valid);

    // R5
    result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(grp_valid && grp_last));

    // R6
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && grp_bad && !grp_first) |=> acc_q == $past(acc_q));

    // R3
    clear_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_first && grp_bad) |=> acc_q == $past(init_c));

    // R8
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_first && state_q != S_RUN)
            |=> (acc_q == $past(acc_q) && !idx_err));

    // R7
    no_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> (!idx_err && acc_q == $past(acc_q)));

endmodule

// File: rtl/sparse_dot24.sv
module sparse_dot24 #(
    parameter int DW   = 8,
    parameter int AW   = 32,
    parameter int GRP  = 4,
    parameter int KEEP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grp_valid,
    input  logic                      grp_first,
    input  logic                      grp_last,
    input  logic [KEEP*DW-1:0]        wt_val,
    input  logic [KEEP*$clog2(GRP)-1:0] wt_idx,
    input  logic [GRP*DW-1:0]         act,
    input  logic [AW-1:0]             init_c,
    output logic [AW-1:0]             res_data,
    output logic                      res_valid,
    output logic                      idx_err
);

    localparam int IW = $clog2(GRP);

    logic [KEEP*DW-1:0] sel_act;
    logic [KEEP*AW-1:0] prods;
    logic [AW-1:0]      grp_sum;
    logic               grp_bad;

    for (genvar k = 0; k < KEEP; k++) begin : g_slot
        sd24_lane_sel #(.DW(DW), .GRP(GRP), .IW(IW)) u_sel (
            .lanes  (act),
            .pick   (wt_idx[k*IW +: IW]),
            .chosen (sel_act[k*DW +: DW])
        );
        sd24_mul #(.DW(DW), .AW(AW)) u_mul (
            .op_w (wt_val[k*DW +: DW]),
            .op_a (sel_act[k*DW +: DW]),
            .prod (prods[k*AW +: AW])
        );
    end

    always_comb begin
        grp_sum = '0;
        for (int k = 0; k < KEEP; k++) begin
            grp_sum = grp_sum + prods[k*AW +: AW];
        end
    end

    always_comb begin
        grp_bad = 1'b0;
        for (int k = 1; k < KEEP; k++) begin
            if (wt_idx[k*IW +: IW] <= wt_idx[(k-1)*IW +: IW]) grp_bad = 1'b1;
        end
    end

    sd24_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_valid (grp_valid),
        .grp_first (grp_first),
        .grp_last  (grp_last),
        .grp_bad   (grp_bad),
        .grp_sum   (grp_sum),
        .init_c    (init_c),
        .res_data  (res_data),
        .res_valid (res_valid),
        .idx_err   (idx_err)
    );

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |-> $past(grp_valid));

endmodule

// File: tb/tb_sparse_dot24.sv
module tb_sparse_dot24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_valid = 1'b0, grp_first = 1'b0, grp_last = 1'b0;
    logic [15:0] wt_val = '0;
    logic [3:0]  wt_idx = '0;
    logic [31:0] act = '0, init_c = '0;
    logic [31:0] res_data;
    logic        res_valid, idx_err;

    int total = 0;
    int bad = 0;

    logic [31:0] m_acc = '0;
    logic        m_open = 1'b0;

    always #5 clk = ~clk;

    sparse_dot24 dut (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_first(grp_first),
        .grp_last(grp_last), .wt_val(wt_val), .wt_idx(wt_idx), .act(act),
        .init_c(init_c), .res_data(res_data), .res_valid(res_valid), .idx_err(idx_err)
    );

    function automatic logic [31:0] contrib(logic [15:0] wv, logic [3:0] wi, logic [31:0] a);
        logic signed [31:0] s = 0;
        for (int k = 0; k < 2; k++) begin
            logic signed [7:0] w, x;
            w = wv[8*k +: 8];
            x = a[8*wi[2*k +: 2] +: 8];
            s = s + w * x;
        end
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step(logic v, logic f, logic l, logic [15:0] wv, logic [3:0] wi,
                        logic [31:0] a, logic [31:0] c, string req);
        logic acc_ok, badi, exp_rv, exp_err;
        @(negedge clk);
        grp_valid = v; grp_first = f; grp_last = l;
        wt_val = wv; wt_idx = wi; act = a; init_c = c;
        @(posedge clk);
        #1;
        acc_ok = v && (f || m_open);
        badi = wi[1:0] >= wi[3:2];
        exp_rv = 1'b0; exp_err = 1'b0;
        if (acc_ok) begin
            m_acc = (f ? c : m_acc) + (badi ? 32'd0 : contrib(wv, wi, a));
            m_open = !l;
            exp_rv = l;
            exp_err = badi;
        end
        chk({req, " valid"}, {31'd0, res_valid}, {31'd0, exp_rv});
        chk({req, " err"}, {31'd0, idx_err}, {31'd0, exp_err});
        if (exp_rv) chk({req, " data"}, res_data, m_acc);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2403));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 err", {31'd0, idx_err}, 32'd0);
        chk("R1 data", res_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 single-group dot, lanes 1 and 3
        step(1, 1, 1, {8'd3, 8'hFE}, {2'd3, 2'd1}, {8'd10, 8'd20, 8'd30, 8'd40}, 32'd100, "R2");
        // R9 back-to-back, R4 multi-group accumulation
        step(1, 1, 0, {8'h80, 8'h80}, {2'd1, 2'd0}, {8'd0, 8'd0, 8'h80, 8'h80}, 32'd0, "R9");
        step(1, 0, 0, {8'h7F, 8'h81}, {2'd3, 2'd2}, 32'h80_7F_11_22, 32'd999, "R4");
        // R7 idle cycle mid-dot
        step(0, 1, 1, 16'hFFFF, 4'b1101, 32'hFFFF_FFFF, 32'd7, "R7");
        step(1, 0, 1, {8'd1, 8'd1}, {2'd2, 2'd0}, {8'd0, 8'd5, 8'd0, 8'd6}, 32'd0, "R4");
        // R4 wrap modulo 2^32
        step(1, 1, 1, {8'd127, 8'd127}, {2'd3, 2'd0}, {8'd127, 8'd0, 8'd0, 8'd127}, 32'h7FFF_FFF0, "R4 wrap");
        // R6 equal and descending indices
        step(1, 1, 0, {8'd5, 8'd5}, {2'd2, 2'd2}, 32'h0505_0505, 32'd42, "R6 first");
        step(1, 0, 0, {8'd9, 8'd9}, {2'd0, 2'd3}, 32'h0909_0909, 32'd0, "R6 desc");
        step(1, 0, 1, {8'd1, 8'd0}, {2'd1, 2'd0}, {8'd0, 8'd0, 8'd4, 8'd0}, 32'd0, "R6 end");
        // R8 stray non-first group while idle is ignored
        step(0, 0, 0, '0, '0, '0, '0, "R8 gap");
        step(1, 0, 1, {8'd50, 8'd50}, {2'd1, 2'd0}, 32'h3333_3333, 32'd0, "R8 stray");
        step(1, 1, 1, 16'd0, {2'd3, 2'd2}, 32'h7777_7777, 32'd5, "R8 zero");
        // R3 first mid-dot abandons
        step(1, 1, 0, {8'd2, 8'd2}, {2'd1, 2'd0}, 32'h0101_0101, 32'd1000, "R3 open");
        step(1, 1, 1, {8'd1, 8'd1}, {2'd3, 2'd2}, 32'h0203_0000, 32'd10, "R3 restart");

        // random mix, R2 R4 R5 R6
        for (int i = 0; i < 400; i++) begin
            logic v, f, l;
            logic [1:0] p, q;
            logic [3:0] wi;
            v = ($urandom % 10) != 0;
            f = !m_open || (($urandom % 12) == 0);
            l = ($urandom % 5) == 0;
            p = 2'($urandom); q = 2'($urandom);
            if (($urandom % 10) != 0) begin
                if (p == q) q = p + 2'd1;
                if (p == 2'd3 && q == 2'd0) q = 2'd0;
                wi = (p < q) ? {q, p} : {p, q};
            end else begin
                wi = {p, q};
            end
            step(v, f, l, 16'($urandom), wi, $urandom, $urandom, "R5 rand");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule